// File: doc/BRIEF.md
# Pruned Quadratic Subblock Interleaver with Circular Rate Matcher

This block sits after a rate-1/5 tail-biting convolutional encoder on a short control channel. It takes the five L-bit subblocks produced by the encoder in one transfer. Each subblock is reordered by a permutation taken from a 128-entry quadratic index sequence that is pruned to the block length. The five reordered subblocks are then joined, in order, into one sequence. A leading part of that sequence is kept as a repetition buffer, and its size depends on L. The buffer is read round and round until a fixed frame of M output bits has gone out.

The pruned permutation is never stored as a table of constants. When a block is accepted, the block spends 128 cycles stepping the quadratic generator over x = 1..128. It keeps the first L values that fall below L and writes them to a small address register file. After that it sends one bit per cycle on a valid/ready serial output. The output holds its bit while `out_ready` is low, and it raises `out_last` on the final bit of the frame. On the input side, `in_ready` is high only while the block is idle. A transfer happens on a cycle where both `in_valid` and `in_ready` are high. A length outside 7..24 is rejected with a one-cycle error pulse.

Top module: `ilv_ratematch`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_len` is 0.
- R2: A transfer whose `in_len` is below 7 or above 24 makes `err_len` high for exactly the one cycle after the transfer edge. It produces no output, and `in_ready` stays 1.
- R3: Base value v(x) = (15x + 32x²) mod 128 for x = 1..128. The permutation P for length L lists the values v(x) < L in increasing x order. Interleaved position j of a subblock carries that subblock's bit P[j].
- R4: The joined sequence is the interleaved subblock A (index 0) at positions 0..L-1, then B, C, D and E (indices 1..4) in that order. Subblock s bit i enters on `in_blk[s*24+i]`.
- R5: The buffer size S is 30 for L = 7..9. For L = 10..11 it is 50 when `cfg_long_mid` is 0 and 55 when it is 1, but never more than 5L, so L = 10 always gives 50. It is 60 for L = 12..24.
- R6: Each accepted valid block yields exactly 60 output transfers. Transfer k carries joined-sequence bit (k mod S), and `out_last` is 1 on transfer 59 only.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_last` stay unchanged on the next cycle.
- R8: `in_ready` is 0 from the cycle after a valid transfer until the frame ends. Changes to `in_blk` during that time do not affect the output.
- R9: After the transfer that carries `out_last`, `out_valid` falls and `in_ready` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Subblock set offered |
| in_ready | output | 1 | Block idle, can take a set |
| in_len | input | 5 | Information length L |
| cfg_long_mid | input | 1 | Selects the 55-bit buffer for L of 10 or 11 |
| in_blk | input | 120 | Five subblocks, 24 bits each, A in the low bits |
| out_valid | output | 1 | Output bit offered |
| out_ready | input | 1 | Sink takes the output bit |
| out_bit | output | 1 | Rate-matched serial bit |
| out_last | output | 1 | Final bit of the 60-bit frame |
| err_len | output | 1 | One-cycle pulse on a rejected length |

## Verification
The bench runs every legal length, and both buffer choices for L of 10 and 11, against a bench-side model of the pruned permutation and the cyclic buffer.
- A wrong pruning rule or a wrong generator shows up as misplaced bits within a subblock.
- A wrong subblock order or a wrong L stride shows up as bits from the wrong subblock.
- A buffer size that is off, or not clamped at L = 10, shows up as a repeat that starts at the wrong output index.
- The sink stalls irregularly, so a design that moves ahead or changes its bit while stalled is caught.
- The bench changes the input data during the frame, so a design that reads `in_blk` live is caught.
- Lengths just outside the legal range (6 and 25), as well as 0 and 31, must give a single error pulse and no frame.

// File: rtl/ilv_rm_pkg.sv
package ilv_rm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUILD = 2'd1,
    ST_SEND  = 2'd2
  } rm_state_e;

  // Number of subblocks produced by the rate-1/5 mother code.
  localparam int unsigned NSUB = 5;
endpackage

// File: rtl/ilv_perm_gen.sv
// Steps the quadratic generator across the full base sequence and collects
// the in-range values, in generation order, into an address register file.
module ilv_perm_gen #(
  parameter int unsigned LMAX = 24,
  parameter int unsigned TBL  = 128,
  parameter int unsigned C1   = 15,
  parameter int unsigned C2   = 32,
  localparam int unsigned LW  = $clog2(LMAX + 1),
  localparam int unsigned AW  = $clog2(LMAX),
  localparam int unsigned TW  = $clog2(TBL),
  localparam int unsigned XW  = TW + 1,
  localparam int unsigned PW  = 2 * XW + 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LW-1:0]            len,
  output logic [LMAX-1:0][AW-1:0]  tbl,
  output logic                     done
);
  logic [XW-1:0] x_q;
  logic [LW-1:0] cnt_q;
  logic          busy_q;
  logic [PW-1:0] xe, prod;
  logic [TW-1:0] val;
  logic          keep;

  assign xe   = PW'(x_q);
  assign prod = PW'(C1) * xe + PW'(C2) * xe * xe;
  assign val  = prod[TW-1:0];                 // power-of-two modulus
  assign keep = (val < TW'(len)) && (cnt_q < LW'(LMAX));
  assign done = busy_q && (x_q == XW'(TBL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      x_q    <= XW'(1);
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (keep) cnt_q <= cnt_q + LW'(1);
      if (x_q == XW'(TBL)) busy_q <= 1'b0;
      else                 x_q    <= x_q + XW'(1);
    end
  end

  for (genvar e = 0; e < LMAX; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) tbl[e] <= '0;
      else if (busy_q && keep && (cnt_q == LW'(e))) tbl[e] <= val[AW-1:0];
    end
  end
endmodule

// File: rtl/ilv_pos_seq.sv
// Walks the cyclic buffer: subblock index, rank within subblock, buffer
// position and frame bit count.
module ilv_pos_seq #(
  parameter int unsigned LMAX = 24,
  parameter int unsigned M    = 60,
  localparam int unsigned LW  = $clog2(LMAX + 1),
  localparam int unsigned AW  = $clog2(LMAX),
  localparam int unsigned SW  = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [LW-1:0] len,
  input  logic [SW-1:0] bsize,
  output logic [2:0]    sub,
  output logic [AW-1:0] rank,
  output logic          last
);
  logic [SW-1:0] pos_q, k_q;

  assign last = (k_q == SW'(M - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sub   <= '0;
      rank  <= '0;
      pos_q <= '0;
      k_q   <= '0;
    end else if (adv) begin
      k_q <= k_q + SW'(1);
      if (pos_q == bsize - SW'(1)) begin
        pos_q <= '0;
        sub   <= '0;
        rank  <= '0;
      end else begin
        pos_q <= pos_q + SW'(1);
        if (LW'(rank) == len - LW'(1)) begin
          rank <= '0;
          sub  <= sub + 3'd1;
        end else begin
          rank <= rank + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ilv_ratematch.sv
module ilv_ratematch
  import ilv_rm_pkg::*;
#(
  parameter int unsigned LMIN      = 7,
  parameter int unsigned LMAX      = 24,
  parameter int unsigned M         = 60,
  parameter int unsigned TBL       = 128,
  parameter int unsigned BUF_SHORT = 30,
  parameter int unsigned BUF_MID_A = 50,
  parameter int unsigned BUF_MID_B = 55,
  parameter int unsigned BUF_FULL  = 60,
  parameter int unsigned MID_LO    = 10,
  parameter int unsigned FULL_LO   = 12,
  localparam int unsigned LW = $clog2(LMAX + 1),
  localparam int unsigned AW = $clog2(LMAX),
  localparam int unsigned SW = $clog2(M + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LW-1:0]        in_len,
  input  logic                 cfg_long_mid,
  input  logic [NSUB*LMAX-1:0] in_blk,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit,
  output logic                 out_last,
  output logic                 err_len
);
  rm_state_e state_q;
  logic [NSUB-1:0][LMAX-1:0] blk_q;
  logic [LW-1:0]             len_q;
  logic [SW-1:0]             bs_q, bs_n;
  logic                      accept, len_ok, start, done, fire;
  logic [LMAX-1:0][AW-1:0]   tbl;
  logic [2:0]                sub;
  logic [AW-1:0]             rank, addr;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign len_ok   = (in_len >= LW'(LMIN)) && (in_len <= LW'(LMAX));
  assign start    = accept && len_ok;
  assign out_valid = (state_q == ST_SEND);
  assign fire     = out_valid && out_ready;

  // Buffer size for the offered length, never above 5L.
  always_comb begin
    int unsigned bs, cap;
    cap = NSUB * int'(in_len);
    if (int'(in_len) >= FULL_LO)     bs = BUF_FULL;
    else if (int'(in_len) >= MID_LO) bs = cfg_long_mid ? BUF_MID_B : BUF_MID_A;
    else                             bs = BUF_SHORT;
    if (bs > cap) bs = cap;
    bs_n = SW'(bs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      len_q   <= '0;
      bs_q    <= '0;
      err_len <= 1'b0;
    end else begin
      err_len <= accept && !len_ok;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_BUILD;
          blk_q   <= in_blk;
          len_q   <= in_len;
          bs_q    <= bs_n;
        end
        ST_BUILD: if (done) state_q <= ST_SEND;
        ST_SEND:  if (fire && out_last) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  ilv_perm_gen #(.LMAX(LMAX), .TBL(TBL)) perm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len(in_len),
    .tbl(tbl), .done(done)
  );

  ilv_pos_seq #(.LMAX(LMAX), .M(M)) seq_i (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(fire),
    .len(len_q), .bsize(bs_q), .sub(sub), .rank(rank), .last(out_last)
  );

  assign addr    = tbl[rank];
  assign out_bit = blk_q[sub][addr];
endmodule

// File: rtl/ilv_ratematch_chk.sv
module ilv_ratematch_chk #(
  parameter int unsigned M = 60
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last,
  input logic err_len
);
  logic [$clog2(M+1)-1:0] fires_q;

  always_ff @(posedge clk) begin
    if (!rst_n || (in_valid && in_ready)) fires_q <= '0;
    else if (out_valid && out_ready)      fires_q <= fires_q + 1'b1;
  end

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

  // R6
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (fires_q == ($clog2(M+1))'(M - 1)));

  // R2
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> ($past(in_valid && in_ready) && !out_valid));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
endmodule

bind ilv_ratematch ilv_ratematch_chk #(.M(M)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
  .out_last(out_last), .err_len(err_len)
);

// File: tb/ilv_ratematch_tb_top.sv
module ilv_ratematch_tb_top;
  localparam int LMAX = 24;
  localparam int M    = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, cfg_long_mid = 1'b0, out_ready = 1'b0;
  logic [4:0] in_len = '0;
  logic [5*LMAX-1:0] in_blk = '0;
  logic in_ready, out_valid, out_bit, out_last, err_len;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ilv_ratematch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_len(in_len), .cfg_long_mid(cfg_long_mid), .in_blk(in_blk),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last), .err_len(err_len)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bufsz(input int l, input bit sel);
    int s;
    if (l >= 12) s = 60;
    else if (l >= 10) s = sel ? 55 : 50;
    else s = 30;
    if (s > 5 * l) s = 5 * l;
    return s;
  endfunction

  // j-th surviving entry of the pruned quadratic sequence
  function automatic int perm(input int l, input int j);
    int c = 0;
    for (int x = 1; x <= 128; x++) begin
      int v = (15 * x + 32 * x * x) % 128;
      if (v < l) begin
        if (c == j) return v;
        c++;
      end
    end
    return 0;
  endfunction

  function automatic bit exp_bit(input logic [5*LMAX-1:0] d, input int l, input bit sel, input int k);
    int p = k % bufsz(l, sel);
    int s = p / l;
    int j = p % l;
    return d[s * LMAX + perm(l, j)];
  endfunction

  task automatic run_frame(input int l, input bit sel, input bit stall, input int seed);
    logic [5*LMAX-1:0] d;
    int k = 0;
    int it = 0;
    bit pend = 0;
    logic pb = 0, pl = 0;
    for (int i = 0; i < 5 * LMAX; i++) d[i] = ((i * 7 + seed * 13 + (i / 3) * i) % 5) < 2;
    @(negedge clk);
    in_len = 5'(l); cfg_long_mid = sel; in_blk = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_blk = ~d;
    check(in_ready == 1'b0, "R8 busy", int'(in_ready), 0);
    while (k < M && it < 3000) begin
      bit rdy = stall ? (((it * 5 + seed) % 7) < 4) : 1'b1;
      out_ready = rdy;
      if (pend) begin
        check(out_valid && out_bit == pb && out_last == pl, "R7 hold",
              int'({out_valid, out_bit, out_last}), int'({1'b1, pb, pl}));
        pend = 0;
      end
      if (out_valid) begin
        if (rdy) begin
          bit e = exp_bit(d, l, sel, k);
          check(out_bit == e, $sformatf("R3/R4/R5 L=%0d sel=%0d k=%0d", l, sel, k), int'(out_bit), int'(e));
          check(out_last == (k == M - 1), $sformatf("R6 last k=%0d", k), int'(out_last), int'(k == M - 1));
          k++;
        end else begin
          pend = 1; pb = out_bit; pl = out_last;
        end
      end
      it++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(k == M, "R6 count", k, M);
    check(in_ready && !out_valid, "R9 idle after last", int'({in_ready, out_valid}), 2);
  endtask

  task automatic bad_len(input int l);
    @(negedge clk);
    in_len = 5'(l); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(err_len == 1'b1 && !out_valid, $sformatf("R2 err pulse L=%0d", l), int'(err_len), 1);
    @(negedge clk);
    check(err_len == 1'b0, "R2 single pulse", int'(err_len), 0);
    check(in_ready && !out_valid, "R2 stays idle", int'({in_ready, out_valid}), 2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && err_len == 1'b0, "R1 reset",
          int'({in_ready, out_valid, err_len}), 4);
    for (int l = 7; l <= 24; l++) run_frame(l, 1'b0, (l % 2) == 1, l);
    run_frame(10, 1'b1, 1'b1, 3);
    run_frame(11, 1'b1, 1'b0, 5);
    run_frame(11, 1'b1, 1'b1, 9);
    bad_len(0);
    bad_len(6);
    bad_len(25);
    bad_len(31);
    run_frame(24, 1'b0, 1'b1, 11);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule